// File: doc/BRIEF.md
# 64-bit Compare Timer with Snapshot Read

This peripheral keeps a free-running 64-bit cycle counter and a 64-bit compare value, and raises a one-shot interrupt when the count reaches the compare value. Software reaches it through four 32-bit words on a simple register bus. The bus has a word index, separate read and write strobes, and write and read data. Read data is registered and appears the cycle after the read strobe.

A narrow bus cannot read a 64-bit counter in one access. Reading the low counter word therefore captures the whole count in one cycle: the low half is returned at once and the high half is parked in a holding register, which a later read of the high counter word returns. The compare value is programmed low word first and high word second. The low word is only staged. The high-word write commits both halves and arms the interrupt, so no partial compare value is ever matched.

Arming is handled by a three-state machine:
- `ST_IDLE`: disarmed, no interrupt.
- `ST_ARMED`: waiting for a match.
- `ST_FIRED`: interrupt asserted.

Its transitions are:
- Any state → `ST_IDLE` on a compare-low write (disarm).
- Any state → `ST_ARMED` on a compare-high write (arm).
- `ST_ARMED` → `ST_FIRED` when the count is greater than or equal to the compare value (match).
- `ST_FIRED` holds until one of the compare words is written.

Top module: `cmp_timer64`

## Requirements
- R1: The counter is 64 bits wide and advances by one on every clock after reset. It starts from parameter `RST_COUNT`, which is zero by default.
- R2: Word index 0 is counter low, 1 is counter high, 2 is compare low and 3 is compare high. A read strobe in cycle t puts the selected word on `rdata` in cycle t+1, and `rdata` holds that value until the next read.
- R3: A read of counter low returns bits 31:0 of the count present in the cycle of the read, before that cycle's increment. The same read loads bits 63:32 of that count into the holding register.
- R4: A read of counter high returns the holding register, not the live upper half of the counter.
- R5: Writes to word indices 0 and 1 have no effect on the counter.
- R6: A write to compare low only stages the low word. It leaves the active compare value unchanged, drops `irq` by the next cycle, and enters `ST_IDLE`.
- R7: A write to compare high makes the active compare value {written word, staged low word} and enters `ST_ARMED`. It also drops `irq` by the next cycle.
- R8: Suppose the machine is in `ST_ARMED` and the count in cycle c is greater than or equal to the active compare value. Then `irq` is high from cycle c+1, and it stays high until a compare word is written.
- R9: After reset `irq` is 0, `rdata` is 0, the holding register, the staged low word and the active compare value are 0, and the machine is in `ST_IDLE`.
- R10: A read of compare low returns the staged low word, and a read of compare high returns the upper half of the active compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock; the counter advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Word index of the access |
| wr_en | input | 1 | Write strobe for the selected word |
| rd_en | input | 1 | Read strobe for the selected word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, high in `ST_FIRED` |

## Verification
Several properties are checked on every cycle:
- the counter steps by one;
- the holding register changes only on a low-counter read, and then takes the upper half of the count from that cycle;
- a compare-low write never changes the active compare value;
- any compare write drops `irq`;
- `irq` stays up until such a write;
- `irq` only rises after a cycle in which the count was at or past the compare value.

Other behaviour can only be shown by the bench's scenarios. These are the exact snapshot values, including a held upper half that differs from the live one after a carry. They also cover ignored counter writes, compare readback, the exact cycle of firing after arming with a future or a past compare value, and the absence of firing after a compare-low write that would match if it were committed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        REG_CNT_LO = 2'd0,
        REG_CNT_HI = 2'd1,
        REG_CMP_LO = 2'd2,
        REG_CMP_HI = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } arm_state_e;

endpackage

// File: rtl/tmr_free_counter.sv
module tmr_free_counter #(
    parameter int               WIDTH   = 64,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= RST_VAL;
        end else begin
            count <= count + STEP;
        end
    end

endmodule

// File: rtl/tmr_cmp_regs.sv
module tmr_cmp_regs #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   stage_lo,
    output logic [2*DATA_W-1:0] cmp_val
);

    localparam int FULL_W = 2 * DATA_W;

    // Low word waits in the stage until the high word commits both halves.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_lo <= '0;
        end else if (wr_lo) begin
            stage_lo <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_val <= '0;
        end else if (wr_hi) begin
            cmp_val <= FULL_W'({wdata, stage_lo});
        end
    end

endmodule

// File: rtl/tmr_arm_fsm.sv
module tmr_arm_fsm
    import tmr_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [WIDTH-1:0] count,
    input  logic [WIDTH-1:0] cmp_val,
    output logic             irq
);

    arm_state_e state_q;
    arm_state_e state_d;
    logic       match;

    assign match = (count >= cmp_val);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: compare writes take priority over a match
    always_comb begin
        state_d = state_q;
        if (wr_hi) begin
            state_d = ST_ARMED;
        end else if (wr_lo) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARMED: state_d = match ? ST_FIRED : ST_ARMED;
                ST_FIRED: state_d = ST_FIRED;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_FIRED: irq = 1'b1;
            default:  irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_readback.sv
module tmr_readback
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  reg_sel_e            sel,
    input  logic [2*DATA_W-1:0] count,
    input  logic [DATA_W-1:0]   stage_lo,
    input  logic [DATA_W-1:0]   cmp_hi,
    output logic [DATA_W-1:0]   hold,
    output logic [DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] cnt_word [2];
    logic [DATA_W-1:0] rd_mux;

    for (genvar g = 0; g < 2; g++) begin : g_split
        assign cnt_word[g] = count[g*DATA_W +: DATA_W];
    end

    always_comb begin
        unique case (sel)
            REG_CNT_LO: rd_mux = cnt_word[0];
            REG_CNT_HI: rd_mux = hold;
            REG_CMP_LO: rd_mux = stage_lo;
            REG_CMP_HI: rd_mux = cmp_hi;
            default:    rd_mux = '0;
        endcase
    end

    // Upper half is captured in the same cycle as the low-word read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (rd_en && (sel == REG_CNT_LO)) begin
            hold <= cnt_word[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64
    import tmr_pkg::*;
#(
    parameter int                   DATA_W    = 32,
    parameter logic [2*DATA_W-1:0]  RST_COUNT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int CNT_W = 2 * DATA_W;

    reg_sel_e          sel;
    logic              wr_lo;
    logic              wr_hi;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  cmp_val;
    logic [DATA_W-1:0] stage_lo;
    logic [DATA_W-1:0] hold;

    assign sel   = reg_sel_e'(addr);
    assign wr_lo = wr_en && (sel == REG_CMP_LO);
    assign wr_hi = wr_en && (sel == REG_CMP_HI);

    tmr_free_counter #(
        .WIDTH   (CNT_W),
        .RST_VAL (RST_COUNT)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count)
    );

    tmr_cmp_regs #(
        .DATA_W (DATA_W)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .wdata    (wdata),
        .stage_lo (stage_lo),
        .cmp_val  (cmp_val)
    );

    tmr_arm_fsm #(
        .WIDTH (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .count   (count),
        .cmp_val (cmp_val),
        .irq     (irq)
    );

    tmr_readback #(
        .DATA_W (DATA_W)
    ) u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .sel      (sel),
        .count    (count),
        .stage_lo (stage_lo),
        .cmp_hi   (cmp_val[CNT_W-1:DATA_W]),
        .hold     (hold),
        .rdata    (rdata)
    );

endmodule

// File: rtl/cmp_timer64_chk.sv
module cmp_timer64_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          addr,
    input logic                wr_en,
    input logic                rd_en,
    input logic                irq,
    input logic [2*DATA_W-1:0] count,
    input logic [2*DATA_W-1:0] cmp_val,
    input logic [DATA_W-1:0]   hold
);

    logic started;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started <= 1'b0;
        end else begin
            started <= 1'b1;
        end
    end

    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        started |=> count == $past(count) + 1'b1);

    a_r3_hold_load: assert property (@(posedge clk) disable iff (!rst_n)
        (started && rd_en && addr == 2'd0) |=> hold == $past(count[2*DATA_W-1:DATA_W]));

    a_r4_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !(rd_en && addr == 2'd0)) |=> $stable(hold));

    a_r6_lo_staged: assert property (@(posedge clk) disable iff (!rst_n)
        (started && wr_en && addr == 2'd2) |=> $stable(cmp_val));

    a_r6_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (started && wr_en && addr[1]) |=> !irq);

    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (started && irq && !(wr_en && addr[1])) |=> irq);

    a_r8_no_early_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $rose(irq)) |-> $past(count) >= $past(cmp_val));

endmodule

bind cmp_timer64 cmp_timer64_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .irq     (irq),
    .count   (count),
    .cmp_val (cmp_val),
    .hold    (hold)
);

// File: tb/cmp_timer64_bench.sv
`timescale 1ns/1ps
module cmp_timer64_bench;

    localparam logic [63:0] RST_CNT = 64'h0000_0003_FFFF_FFC0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    logic [63:0] m;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cmp_timer64 #(.DATA_W(32), .RST_COUNT(RST_CNT)) u_cmp_timer64 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // Reference count: value the counter holds during each cycle
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m <= RST_CNT;
        else        m <= m + 64'd1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d, output logic [63:0] mc);
        @(negedge clk);
        addr = a; rd_en = 1'b1; mc = m;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v, output logic [63:0] mc);
        @(negedge clk);
        addr = a; wdata = v; wr_en = 1'b1; mc = m;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Expected irq: armed at the edge ending cycle w_arm
    task automatic watch_irq(input string req, input int n, input logic [63:0] cmp,
                             input logic [63:0] w_arm, input bit armed);
        for (int i = 0; i < n; i++) begin
            chk(req, {63'd0, irq}, {63'd0, armed && (m >= w_arm + 64'd2) && (m > cmp)});
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic [63:0] mc;
        repeat (3) @(negedge clk);
        chk("R9 irq in reset", {63'd0, irq}, 64'd0);
        chk("R9 rdata in reset", {32'd0, rdata}, 64'd0);
        rst_n = 1'b1;
        rd(2'd2, d, mc);
        chk("R9 R10 cmp lo after reset", {32'd0, d}, 64'd0);
        rd(2'd3, d, mc);
        chk("R9 R10 cmp hi after reset", {32'd0, d}, 64'd0);
        rd(2'd1, d, mc);
        chk("R9 hold after reset", {32'd0, d}, 64'd0);
        repeat (4) @(negedge clk);
        chk("R9 disarmed after reset", {63'd0, irq}, 64'd0);
    endtask

    task automatic t_snapshot();
        logic [31:0] d;
        logic [63:0] mc;
        logic [31:0] held;
        rd(2'd0, d, mc);
        chk("R1 R3 low word snapshot", {32'd0, d}, {32'd0, mc[31:0]});
        held = mc[63:32];
        repeat (3) @(negedge clk);
        chk("R2 rdata held between reads", {32'd0, rdata}, {32'd0, mc[31:0]});
        repeat (80) @(negedge clk);
        rd(2'd1, d, mc);
        chk("R4 high word from hold", {32'd0, d}, {32'd0, held});
        chk("R4 live high differs", {63'd0, mc[63:32] != held}, 64'd1);
        rd(2'd0, d, mc);
        chk("R3 second low snapshot", {32'd0, d}, {32'd0, mc[31:0]});
        held = mc[63:32];
        rd(2'd1, d, mc);
        chk("R4 high after new snapshot", {32'd0, d}, {32'd0, held});
    endtask

    task automatic t_ignore_writes();
        logic [31:0] d;
        logic [63:0] mc;
        wr(2'd0, 32'h0000_0000, mc);
        wr(2'd1, 32'hFFFF_0000, mc);
        rd(2'd0, d, mc);
        chk("R5 low unaffected by writes", {32'd0, d}, {32'd0, mc[31:0]});
        rd(2'd1, d, mc);
        chk("R5 high unaffected by writes", {32'd0, d}, {32'd0, mc[63:32]});
    endtask

    task automatic t_arm_future();
        logic [63:0] cmp;
        logic [63:0] mc;
        cmp = m + 64'd30;
        wr(2'd2, cmp[31:0], mc);
        chk("R6 no irq between writes", {63'd0, irq}, 64'd0);
        wr(2'd3, cmp[63:32], mc);
        watch_irq("R7 R8 future match", 60, cmp, mc, 1'b1);
        chk("R8 irq held after match", {63'd0, irq}, 64'd1);
    endtask

    task automatic t_clear_readback();
        logic [31:0] d;
        logic [63:0] mc;
        logic [31:0] old_hi;
        old_hi = m[63:32];
        wr(2'd2, 32'h0000_0007, mc);
        watch_irq("R6 low write clears and disarms", 10, 64'd0, mc, 1'b0);
        rd(2'd2, d, mc);
        chk("R10 cmp lo readback", {32'd0, d}, 64'd7);
        rd(2'd3, d, mc);
        chk("R10 cmp hi readback", {32'd0, d}, {32'd0, old_hi});
    endtask

    task automatic t_arm_past();
        logic [63:0] cmp;
        logic [63:0] mc;
        cmp = m - 64'd5;
        wr(2'd2, cmp[31:0], mc);
        wr(2'd3, cmp[63:32], mc);
        watch_irq("R7 R8 past value fires", 8, cmp, mc, 1'b1);
    endtask

    task automatic t_lo_no_spurious();
        logic [63:0] cmp;
        logic [63:0] mc;
        cmp = m + 64'd1000;
        wr(2'd2, cmp[31:0], mc);
        wr(2'd3, cmp[63:32], mc);
        watch_irq("R7 hi write clears fired irq", 5, cmp, mc, 1'b1);
        wr(2'd2, 32'h0000_0000, mc);
        watch_irq("R6 staged low never matches", 20, 64'd0, mc, 1'b0);
    endtask

    initial begin
        t_reset();
        t_snapshot();
        t_ignore_writes();
        t_arm_future();
        t_clear_readback();
        t_arm_past();
        t_lo_no_spurious();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule